// File: doc/BRIEF.md
# Shadow-Memory Store/Recall Controller

This block sits in front of a static RAM that has a nonvolatile shadow array of the same shape, 2048 words of 8 bits by default (32 rows of 64 bytes). In normal use the host reads and writes the SRAM over a plain chip-enable, output-enable and write-enable bus. The block copies the whole SRAM into the shadow array (STORE) or restores it from the shadow array (RECALL) when one of several triggers asks for it. The SRAM array and the shadow array are modelled inside the block. Each copy pass moves one word per clock.

A STORE starts from a software command, from an external low level on the shared store/busy pin, or from a power-fail event. A RECALL starts from a software command or from a power-up event. A software command is six back-to-back reads at fixed addresses. Any other access breaks the chain. While an operation runs, the block holds off the host, pulls the store/busy pin low and keeps the memory out of standby. Each operation lasts a fixed, configurable number of clock cycles, which models the nonvolatile cycle time. A one-cycle pulse marks the end of the operation.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `hsb_pull_low` and `dout_en` are all low.
- R2: Every clock cycle with `ce_n` low is one host access. With `we_n` low, `din` is written at `addr` on the clock edge. With `we_n` high and `oe_n` low, `dout` shows the word at `addr` and `dout_en` is high. In every other case `dout_en` is low.
- R3: Six consecutive reads at `SEQ_A0`, `SEQ_A1`, `SEQ_A2`, `SEQ_A3`, `SEQ_A4` and then `STORE_SEL` start a STORE. The same five reads followed by `RECALL_SEL` start a RECALL. `busy` is high in the cycle after the final read.
- R4: Between steps, a read at any address other than the expected one restarts detection, and so does any write, including a write to a sequence address. A restarting read at `SEQ_A0` counts as the first step again. A wrong final address starts nothing.
- R5: A low level on `hsb_n_in` while the block is idle starts a STORE. While an operation runs, the pin is not treated as a request.
- R6: A `pwr_fail_evt` pulse starts a STORE and a `pwr_up_evt` pulse starts a RECALL. When triggers arrive together, the priority order is power-fail, then the pin, then the software command, then power-up.
- R7: A STORE copies every SRAM word into the shadow array, and `busy` stays high for exactly `STORE_CYC` cycles.
- R8: A RECALL first clears every SRAM word and then copies every shadow word into the SRAM. It does not change the shadow array. `busy` stays high for exactly `RECALL_CYC` cycles.
- R9: While `busy` is high, host writes have no effect, `dout_en` stays low, no command steps are counted, and power and pin triggers are dropped.
- R10: `hsb_pull_low` (drive the open-drain store/busy pin low) is high in exactly the cycles in which `busy` is high.
- R11: `done` is high for one cycle, the first idle cycle after each operation.
- R12: `standby` is high only when `ce_n` is high and no operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data |
| dout_en | output | 1 | Read data is being driven |
| hsb_n_in | input | 1 | Level sensed on the store/busy pin |
| hsb_pull_low | output | 1 | Pull the store/busy pin low |
| pwr_fail_evt | input | 1 | One-cycle power-fail indication |
| pwr_up_evt | input | 1 | One-cycle power-up indication |
| busy | output | 1 | STORE or RECALL in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| standby | output | 1 | Memory may enter standby |

## Verification
The bench builds the block with a 4-bit address, so the memory has 16 words. This lets every word be written, stored, overwritten and recalled in full sweeps and compared with patterns computed in the bench. The operation lengths are cut to 40 cycles for STORE and 50 for RECALL. Both still exceed one or two full passes over the array, so every busy window can be counted cycle by cycle. The sequence addresses are set to distinct small values. The bench can then insert foreign reads, writes to sequence addresses, wrong final addresses and restarting reads, and check that only complete chains start an operation.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_RECALL} nvs_state_e;
  typedef enum logic [1:0] {PASS_A, PASS_B, PASS_WAIT} nvs_pass_e;

  // which pass a cycle count falls into, for an array of 'depth' words
  function automatic nvs_pass_e pass_of(int cnt, int depth);
    if (cnt < depth) return PASS_A;
    if (cnt < 2 * depth) return PASS_B;
    return PASS_WAIT;
  endfunction

  // total busy length of an operation in cycles
  function automatic int op_len(nvs_state_e s, int store_cyc, int recall_cyc);
    case (s)
      ST_STORE:  return store_cyc;
      ST_RECALL: return recall_cyc;
      default:   return 1;
    endcase
  endfunction
endpackage

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect #(
  parameter int AW = 11,
  parameter logic [AW-1:0] SEQ_A0 = '0,
  parameter logic [AW-1:0] SEQ_A1 = '0,
  parameter logic [AW-1:0] SEQ_A2 = '0,
  parameter logic [AW-1:0] SEQ_A3 = '0,
  parameter logic [AW-1:0] SEQ_A4 = '0,
  parameter logic [AW-1:0] STORE_SEL = '0,
  parameter logic [AW-1:0] RECALL_SEL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [AW-1:0] addr,
  output logic          sw_store,
  output logic          sw_recall
);
  localparam logic [2:0] LAST = 3'd5;

  logic [2:0]    step;
  logic [AW-1:0] want;
  logic          at_last;

  always_comb begin
    case (step)
      3'd0:    want = SEQ_A0;
      3'd1:    want = SEQ_A1;
      3'd2:    want = SEQ_A2;
      3'd3:    want = SEQ_A3;
      default: want = SEQ_A4;
    endcase
  end

  assign at_last   = (step == LAST);
  assign sw_store  = acc_rd && at_last && (addr == STORE_SEL);
  assign sw_recall = acc_rd && at_last && (addr == RECALL_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || acc_wr) begin
      step <= '0;
    end else if (acc_rd) begin
      if (sw_store || sw_recall)           step <= '0;
      else if (!at_last && addr == want)   step <= step + 3'd1;
      else                                 step <= (addr == SEQ_A0) ? 3'd1 : 3'd0;
    end
  end

  assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST);
  assert_abort_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> step == 3'd0);
endmodule

// File: rtl/nvs_op_fsm.sv
module nvs_op_fsm
  import nvs_pkg::*;
#(
  parameter int AW = 11,
  parameter int STORE_CYC = 2500000,
  parameter int RECALL_CYC = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_evt,
  input  logic          hw_req,
  input  logic          sw_store,
  input  logic          sw_recall,
  input  logic          pu_evt,
  output logic          busy,
  output logic          done,
  output logic          eng_st,
  output logic          eng_clr,
  output logic          eng_rc,
  output logic [AW-1:0] eng_idx
);
  localparam int DEPTH = 1 << AW;
  localparam int MAXC  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  nvs_state_e    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  nvs_pass_e     pass;
  logic          op_end;

  assign busy    = (state != ST_IDLE);
  assign last    = CW'(op_len(state, STORE_CYC, RECALL_CYC) - 1);
  assign op_end  = busy && (cnt == last);
  assign pass    = pass_of(int'(cnt), DEPTH);
  assign eng_st  = (state == ST_STORE)  && (pass == PASS_A);
  assign eng_clr = (state == ST_RECALL) && (pass == PASS_A);
  assign eng_rc  = (state == ST_RECALL) && (pass == PASS_B);
  assign eng_idx = cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        cnt <= '0;
        if (pf_evt || hw_req || sw_store) state <= ST_STORE;
        else if (sw_recall || pu_evt)     state <= ST_RECALL;
      end else if (op_end) begin
        state <= ST_IDLE;
        cnt   <= '0;
        done  <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> int'(cnt) < op_len(state, STORE_CYC, RECALL_CYC));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_follows_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  assert_copy_after_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rc |-> $past(state) == ST_RECALL);
endmodule

// File: rtl/nvs_mem.sv
module nvs_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  input  logic          eng_st,
  input  logic          eng_clr,
  input  logic          eng_rc,
  input  logic [AW-1:0] eng_idx
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] sram   [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  assign host_dout = sram[host_addr];

  always_ff @(posedge clk) begin
    if (host_we)      sram[host_addr] <= host_din;
    else if (eng_clr) sram[eng_idx]   <= '0;
    else if (eng_rc)  sram[eng_idx]   <= shadow[eng_idx];
    if (eng_st)       shadow[eng_idx] <= sram[eng_idx];
  end

  assert_host_locked_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |-> !(eng_st || eng_clr || eng_rc));
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int STORE_CYC = 2500000,
  parameter int RECALL_CYC = 5000,
  parameter logic [AW-1:0] SEQ_A0 = AW'(11'h4E5),
  parameter logic [AW-1:0] SEQ_A1 = AW'(11'h21A),
  parameter logic [AW-1:0] SEQ_A2 = AW'(11'h6B3),
  parameter logic [AW-1:0] SEQ_A3 = AW'(11'h14C),
  parameter logic [AW-1:0] SEQ_A4 = AW'(11'h735),
  parameter logic [AW-1:0] STORE_SEL = AW'(11'h0C3),
  parameter logic [AW-1:0] RECALL_SEL = AW'(11'h3C4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic          hsb_n_in,
  output logic          hsb_pull_low,
  input  logic          pwr_fail_evt,
  input  logic          pwr_up_evt,
  output logic          busy,
  output logic          done,
  output logic          standby
);
  logic acc_rd, acc_wr, sw_store, sw_recall;
  logic eng_st, eng_clr, eng_rc;
  logic [AW-1:0] eng_idx;

  assign acc_rd       = !ce_n && we_n && !busy;
  assign acc_wr       = !ce_n && !we_n && !busy;
  assign dout_en      = acc_rd && !oe_n;
  assign hsb_pull_low = busy;
  assign standby      = ce_n && !busy;

  nvs_seq_detect #(
    .AW(AW), .SEQ_A0(SEQ_A0), .SEQ_A1(SEQ_A1), .SEQ_A2(SEQ_A2),
    .SEQ_A3(SEQ_A3), .SEQ_A4(SEQ_A4), .STORE_SEL(STORE_SEL), .RECALL_SEL(RECALL_SEL)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .clear(busy), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .addr(addr), .sw_store(sw_store), .sw_recall(sw_recall)
  );

  nvs_op_fsm #(.AW(AW), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) fsm_i (
    .clk(clk), .rst_n(rst_n), .pf_evt(pwr_fail_evt), .hw_req(!hsb_n_in),
    .sw_store(sw_store), .sw_recall(sw_recall), .pu_evt(pwr_up_evt),
    .busy(busy), .done(done), .eng_st(eng_st), .eng_clr(eng_clr),
    .eng_rc(eng_rc), .eng_idx(eng_idx)
  );

  nvs_mem #(.AW(AW), .DW(DW)) mem_i (
    .clk(clk), .rst_n(rst_n), .host_we(acc_wr), .host_addr(addr), .host_din(din),
    .host_dout(dout), .eng_st(eng_st), .eng_clr(eng_clr), .eng_rc(eng_rc),
    .eng_idx(eng_idx)
  );

  assert_no_read_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_en);
  assert_busy_on_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_store || sw_recall) |=> busy);
endmodule

// File: tb/nvs_ctrl_tb_top.sv
module nvs_ctrl_tb_top;
  localparam int AW = 4, DW = 8, SC = 40, RC = 50, N = 1 << AW;
  localparam logic [AW-1:0] A0 = 4'd1, A1 = 4'd9, A2 = 4'd4, A3 = 4'd12, A4 = 4'd6;
  localparam logic [AW-1:0] SSEL = 4'd3, RSEL = 4'd13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, hsb_pull_low, busy, done, standby;
  logic ext_pull = 1'b0, pf = 1'b0, pu = 1'b0;
  logic hsb_n_in;
  int total = 0, bad = 0;

  assign hsb_n_in = !(ext_pull || hsb_pull_low);
  always #4 clk = !clk;

  nvs_ctrl #(.AW(AW), .DW(DW), .STORE_CYC(SC), .RECALL_CYC(RC),
    .SEQ_A0(A0), .SEQ_A1(A1), .SEQ_A2(A2), .SEQ_A3(A3), .SEQ_A4(A4),
    .STORE_SEL(SSEL), .RECALL_SEL(RSEL)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .hsb_n_in(hsb_n_in),
    .hsb_pull_low(hsb_pull_low), .pwr_fail_evt(pf), .pwr_up_evt(pu),
    .busy(busy), .done(done), .standby(standby));

  function automatic logic [DW-1:0] pat(int k, int a);
    return DW'(a * (2 * k + 5) + 17 * k + 3);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one access cycle, called at a negedge, returns at the next negedge
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask
  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
    ce_n = 0; we_n = 1; oe_n = 0; addr = a;
    #1; d = dout; en = dout_en;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask
  task automatic rd_q(logic [AW-1:0] a);
    logic [DW-1:0] d; logic en;
    rd(a, d, en);
  endtask
  task automatic fill(int k);
    for (int a = 0; a < N; a++) wr(AW'(a), pat(k, a));
  endtask
  task automatic verify(int k, string req);
    logic [DW-1:0] d; logic en; int errs = 0; int first = 0;
    for (int a = 0; a < N; a++) begin
      rd(AW'(a), d, en);
      if (!en || d != pat(k, a)) begin
        if (errs == 0) first = a;
        errs++;
      end
    end
    chk(errs == 0, req, errs, 0);
    if (errs != 0) $display("  first mismatch at word %0d", first);
  endtask
  task automatic prefix();
    rd_q(A0); rd_q(A1); rd_q(A2); rd_q(A3); rd_q(A4);
  endtask
  // count busy cycles starting from 'already', then check the done pulse
  task automatic wait_op(int exp, int already, string req);
    int n = already; int pin_err = 0;
    while (busy && n < 1000) begin
      if (!hsb_pull_low) pin_err++;
      n++;
      @(negedge clk);
    end
    chk(n == exp, req, n, exp);
    chk(pin_err == 0 && !hsb_pull_low, "R10 pin low during op", pin_err, 0);
    chk(done == 1'b1, "R11 done high", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R11 done single cycle", int'(done), 0);
  endtask
  task automatic quiet(string req);
    int hits = 0;
    for (int i = 0; i < 3; i++) begin
      if (busy) hits++;
      @(negedge clk);
    end
    chk(hits == 0, req, hits, 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d; logic en;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(!busy && !done && !hsb_pull_low && !dout_en, "R1 reset idle",
        {busy, done, hsb_pull_low, dout_en}, 0);
    chk(standby, "R12 standby when deselected and idle", int'(standby), 1);

    // R2 basic SRAM mode
    fill(0);
    verify(0, "R2 read back sweep");
    ce_n = 0; we_n = 1; oe_n = 1; addr = 4'd5; #1;
    chk(!dout_en && !standby, "R2 output enable high keeps outputs off",
        {dout_en, standby}, 0);
    @(negedge clk); ce_n = 1;

    // R3/R7 software store
    prefix(); rd_q(SSEL);
    chk(busy, "R3 store sequence starts op", int'(busy), 1);
    wait_op(SC, 0, "R7 store length");
    fill(1);
    verify(1, "R2 overwrite");
    // R3/R8 software recall restores stored image
    prefix(); rd_q(RSEL);
    chk(busy, "R3 recall sequence starts op", int'(busy), 1);
    wait_op(RC, 0, "R8 recall length");
    verify(0, "R8 recall restores stored image");

    // R5 pin request, R9 blocking during op
    ext_pull = 1; @(negedge clk); ext_pull = 0;
    chk(busy, "R5 pin request starts store", int'(busy), 1);
    wr(4'd2, 8'hEE);
    rd(4'd7, d, en);
    chk(!en, "R9 no read data while busy", int'(en), 0);
    ce_n = 1; #1;
    chk(!standby, "R12 no standby during op", int'(standby), 0);
    pu = 1; ext_pull = 1; @(negedge clk); pu = 0; ext_pull = 0;
    prefix(); rd_q(RSEL);
    wait_op(SC, 9, "R5 pin store length");
    quiet("R9 triggers during op dropped");
    rd(4'd2, d, en);
    chk(en && d == pat(0, 2), "R9 write during op ignored", int'(d), int'(pat(0, 2)));

    // R4 aborted sequences
    rd_q(A0); rd_q(A1); rd_q(4'd0); rd_q(A2); rd_q(A3); rd_q(A4); rd_q(SSEL);
    quiet("R4 foreign read aborts");
    rd_q(A0); rd_q(A1); rd_q(A2); wr(A3, 8'h00); rd_q(A3); rd_q(A4); rd_q(SSEL);
    quiet("R4 write to sequence address aborts");
    prefix(); rd_q(4'd0);
    quiet("R4 wrong final address");
    rd_q(A0); rd_q(A1); rd_q(A0); rd_q(A1); rd_q(A2); rd_q(A3); rd_q(A4); rd_q(SSEL);
    chk(busy, "R4 restart from first step", int'(busy), 1);
    wait_op(SC, 0, "R4 restarted store length");

    // R6 power events
    fill(2);
    pf = 1; @(negedge clk); pf = 0;
    chk(busy, "R6 power fail starts store", int'(busy), 1);
    wait_op(SC, 0, "R6 power fail store length");
    fill(3);
    pu = 1; @(negedge clk); pu = 0;
    wait_op(RC, 0, "R6 power up recall length");
    verify(2, "R6 power up recall data");
    pf = 1; pu = 1; @(negedge clk); pf = 0; pu = 0;
    wait_op(SC, 0, "R6 power fail wins over power up");
    fill(3);
    prefix(); rd_q(RSEL);
    wait_op(RC, 0, "R8 second recall length");
    verify(2, "R8 shadow unchanged by recall");
    prefix(); rd_q(RSEL);
    wait_op(RC, 0, "R8 third recall length");
    verify(2, "R8 repeated recall");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule